// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block maintains the exception bookkeeping of a floating-point status word once each FP operation finishes. The execution pipe signals completion with a one-cycle strobe. Alongside the strobe it supplies the five exception flags the operation produced, whether the operation writes a destination register, whether that destination is a double, and the destination index. The unit compares the new flags with a software-loaded trap-enable mask. It then updates the current and accrued exception fields and the trap-type field. When an enabled exception occurs, it raises a trap request during the completion cycle.

When an operation completes without trapping, the unit moves the program counter pair forward by one instruction. It also marks the half of the FP register file that the result landed in as dirty. A trapping operation leaves the program counter pair, the dirty bits and the accrued field alone, so a handler sees the state from before the faulting instruction.

Top module: `fpx_status_unit`

## Requirements
- R1: After reset, the trap-enable mask, current field, accrued field, trap type and both dirty bits are zero, `pc_o` equals `RESET_PC` (0x100 by default), `npc_o` equals `RESET_PC + 4`, and `trap_req` is low.
- R2: A completing operation with no exception flags clears the current field on the next clock and keeps the accrued field and trap type.
- R3: A completing operation whose flags are nonzero but all masked loads the flags into the current field, ORs them into the accrued field, keeps the trap type and raises no trap. Flag bit order, MSB to LSB: invalid, overflow, underflow, divide-by-zero, inexact.
- R4: When the flags ANDed with the mask are nonzero, `trap_req` is high in the completion cycle only. On the next clock the current field holds the flags, the accrued field is unchanged and the trap type is 1 (IEEE-754 exception).
- R5: A trapping operation leaves `pc_o`, `npc_o` and `dirty_o` unchanged, even when it would write a register.
- R6: A non-trapping completion sets `pc_o` to the previous `npc_o` and `npc_o` to the previous `npc_o + 4`.
- R7: A non-trapping completion that writes a register sets one dirty bit and keeps the other. Bit 1 (upper half) is set for a double destination with index of 32 or more. Bit 0 (lower half) is set for every other write, including all single destinations. A non-writing operation leaves the dirty bits alone.
- R8: A mask write takes effect on the next clock. An operation that completes in the same cycle as the write is judged against the old mask.
- R9: `status_word` carries the current field in bits [4:0], the accrued field in [9:5], the trap type in [16:14] and the mask in [27:23]. All other bits are zero.
- R10: While `op_done` is low, the exception fields, trap type, PC pair and dirty bits do not change, whatever the other operation inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_done | input | 1 | One-cycle strobe: an FP operation completed |
| op_exc | input | 5 | Exception flags raised by the completing operation |
| op_writes | input | 1 | The operation writes a destination register |
| op_dbl | input | 1 | The destination is a double register |
| op_rd | input | RD_W (6) | Destination register index |
| tem_wr_en | input | 1 | Load the trap-enable mask |
| tem_wr_data | input | 5 | New trap-enable mask |
| trap_req | output | 1 | IEEE-754 trap request, high in the completion cycle |
| status_word | output | 32 | Packed status: current, accrued, trap type, mask |
| pc_o | output | PC_W (32) | Program counter |
| npc_o | output | PC_W (32) | Next program counter |
| dirty_o | output | 2 | Dirty bits: [0] lower half, [1] upper half of the register file |

## Verification
A mask write and an operation completion can land in the same cycle. The question then is whether the trap decision uses the mask from before or after the write. The bench provokes this by writing a mask that enables overflow while an overflow-raising operation completes. It expects no trap and an accrued overflow flag for that operation, and a trap for a second overflow operation in the following cycle. A trap directly followed by a clean operation in back-to-back cycles confirms that the trap request is a single-cycle pulse, and that the clean operation alone advances the PC pair.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int EXC_W    = 5;
    localparam int FTT_W    = 3;
    localparam int STATUS_W = 32;

    // Field positions inside the packed status word
    localparam int CEXC_LSB = 0;
    localparam int AEXC_LSB = CEXC_LSB + EXC_W;
    localparam int FTT_LSB  = 14;
    localparam int TEM_LSB  = 23;

    // Exception bit positions within every 5-bit field
    localparam int EXC_NX = 0;  // inexact
    localparam int EXC_DZ = 1;  // divide by zero
    localparam int EXC_UF = 2;  // underflow
    localparam int EXC_OF = 3;  // overflow
    localparam int EXC_NV = 4;  // invalid

    localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

    typedef logic [EXC_W-1:0] exc_t;

    typedef struct packed {
        exc_t              tem;
        exc_t              cexc;
        exc_t              aexc;
        logic [FTT_W-1:0]  ftt;
    } exc_state_t;

    typedef enum logic [1:0] {
        OUT_CLEAN   = 2'd0,
        OUT_FLAGGED = 2'd1,
        OUT_TRAP    = 2'd2
    } outcome_e;

    function automatic outcome_e classify(exc_t raised, exc_t mask);
        if (raised == '0)
            return OUT_CLEAN;
        else if ((raised & mask) != '0)
            return OUT_TRAP;
        else
            return OUT_FLAGGED;
    endfunction

endpackage

// File: rtl/fpx_exc_fields.sv
module fpx_exc_fields
    import fpx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_done,
    input  exc_t       op_exc,
    input  logic       tem_wr_en,
    input  exc_t       tem_wr_data,
    output logic       trap_req,
    output exc_state_t state_o
);

    exc_state_t st_d;
    exc_state_t st_q;
    outcome_e   kind;

    always_comb begin
        st_d     = st_q;
        kind     = classify(op_exc, st_q.tem);
        trap_req = op_done && (kind == OUT_TRAP);

        if (op_done) begin
            case (kind)
                OUT_CLEAN: begin
                    st_d.cexc = '0;
                end
                OUT_FLAGGED: begin
                    st_d.cexc = op_exc;
                    st_d.aexc = st_q.aexc | op_exc;
                end
                OUT_TRAP: begin
                    st_d.cexc = op_exc;
                    st_d.ftt  = FTT_IEEE;
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end

        // the mask write lands after the decision above used the old mask
        if (tem_wr_en) begin
            st_d.tem = tem_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/fpx_pc_seq.sv
module fpx_pc_seq #(
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = 'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [PC_W-1:0] pc_o,
    output logic [PC_W-1:0] npc_o
);

    localparam logic [PC_W-1:0] STRIDE    = PC_W'(INSN_BYTES);
    localparam logic [PC_W-1:0] RESET_NPC = RESET_PC + STRIDE;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [PC_W-1:0] npc;
    } pc_state_t;

    pc_state_t pcs_d;
    pc_state_t pcs_q;

    always_comb begin
        pcs_d = pcs_q;
        if (step) begin
            pcs_d.pc  = pcs_q.npc;
            pcs_d.npc = pcs_q.npc + STRIDE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcs_q.pc  <= RESET_PC;
            pcs_q.npc <= RESET_NPC;
        end else begin
            pcs_q <= pcs_d;
        end
    end

    assign pc_o  = pcs_q.pc;
    assign npc_o = pcs_q.npc;

endmodule

// File: rtl/fpx_dirty_track.sv
module fpx_dirty_track #(
    parameter int RD_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mark,
    input  logic            op_dbl,
    input  logic [RD_W-1:0] op_rd,
    output logic [1:0]      dirty_o
);

    localparam int              NUM_HALVES = 2;
    localparam logic [RD_W-1:0] UPPER_BASE = RD_W'(1 << (RD_W - 1));

    logic                  upper_sel;
    logic [NUM_HALVES-1:0] set_vec;
    logic [NUM_HALVES-1:0] dirty_d;
    logic [NUM_HALVES-1:0] dirty_q;

    // singles always live in the lower half; only doubles reach the upper
    assign upper_sel = op_dbl && (op_rd >= UPPER_BASE);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        if (h == 0) begin : g_lo
            assign set_vec[h] = mark && !upper_sel;
        end else begin : g_hi
            assign set_vec[h] = mark && upper_sel;
        end
    end

    always_comb begin
        dirty_d = dirty_q | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= '0;
        end else begin
            dirty_q <= dirty_d;
        end
    end

    assign dirty_o = dirty_q;

endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
    import fpx_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = 'h100,
    parameter int              RD_W       = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_done,
    input  logic [EXC_W-1:0]    op_exc,
    input  logic                op_writes,
    input  logic                op_dbl,
    input  logic [RD_W-1:0]     op_rd,
    input  logic                tem_wr_en,
    input  logic [EXC_W-1:0]    tem_wr_data,
    output logic                trap_req,
    output logic [STATUS_W-1:0] status_word,
    output logic [PC_W-1:0]     pc_o,
    output logic [PC_W-1:0]     npc_o,
    output logic [1:0]          dirty_o
);

    exc_state_t exc_st;
    logic       advance;
    logic       mark_dirty;

    fpx_exc_fields u_exc (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_done     (op_done),
        .op_exc      (op_exc),
        .tem_wr_en   (tem_wr_en),
        .tem_wr_data (tem_wr_data),
        .trap_req    (trap_req),
        .state_o     (exc_st)
    );

    assign advance    = op_done && !trap_req;
    assign mark_dirty = advance && op_writes;

    fpx_pc_seq #(
        .PC_W       (PC_W),
        .INSN_BYTES (INSN_BYTES),
        .RESET_PC   (RESET_PC)
    ) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (advance),
        .pc_o  (pc_o),
        .npc_o (npc_o)
    );

    fpx_dirty_track #(
        .RD_W (RD_W)
    ) u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .mark    (mark_dirty),
        .op_dbl  (op_dbl),
        .op_rd   (op_rd),
        .dirty_o (dirty_o)
    );

    always_comb begin
        status_word                         = '0;
        status_word[CEXC_LSB +: EXC_W]      = exc_st.cexc;
        status_word[AEXC_LSB +: EXC_W]      = exc_st.aexc;
        status_word[FTT_LSB  +: FTT_W]      = exc_st.ftt;
        status_word[TEM_LSB  +: EXC_W]      = exc_st.tem;
    end

endmodule

// File: rtl/fpx_status_unit_chk.sv
module fpx_status_unit_chk #(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_done,
    input logic [4:0]      op_exc,
    input logic            tem_wr_en,
    input logic [4:0]      tem_wr_data,
    input logic            trap_req,
    input logic [4:0]      cexc,
    input logic [4:0]      aexc,
    input logic [2:0]      ftt,
    input logic [4:0]      tem,
    input logic [PC_W-1:0] pc_o,
    input logic [PC_W-1:0] npc_o,
    input logic [1:0]      dirty_o
);

    AST_CLEAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_exc == 5'd0) |=> (cexc == 5'd0 && $stable(aexc) && $stable(ftt))); // R2

    AST_ACCRUE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !trap_req) |=> ((aexc & $past(aexc)) == $past(aexc))); // R3

    AST_TRAP_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> op_done); // R4

    AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> ($stable(aexc) && ftt == 3'd1 && cexc == $past(op_exc))); // R4

    AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> ($stable(pc_o) && $stable(npc_o) && $stable(dirty_o))); // R5

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !trap_req) |=> (pc_o == $past(npc_o) &&
                                    npc_o == $past(npc_o) + PC_W'(INSN_BYTES))); // R6

    AST_DIRTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> ((dirty_o & $past(dirty_o)) == $past(dirty_o))); // R7

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tem_wr_en |=> (tem == $past(tem_wr_data))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_done |=> ($stable(cexc) && $stable(aexc) && $stable(ftt) &&
                      $stable(pc_o) && $stable(npc_o) && $stable(dirty_o))); // R10

endmodule

bind fpx_status_unit fpx_status_unit_chk #(
    .PC_W       (PC_W),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_done     (op_done),
    .op_exc      (op_exc),
    .tem_wr_en   (tem_wr_en),
    .tem_wr_data (tem_wr_data),
    .trap_req    (trap_req),
    .cexc        (status_word[4:0]),
    .aexc        (status_word[9:5]),
    .ftt         (status_word[16:14]),
    .tem         (status_word[27:23]),
    .pc_o        (pc_o),
    .npc_o       (npc_o),
    .dirty_o     (dirty_o)
);

// File: tb/fpx_status_unit_tb.sv
`timescale 1ns/1ps
module fpx_status_unit_tb;

    localparam int          PC_W     = 32;
    localparam logic [31:0] RESET_PC = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_done = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_writes = 1'b0;
    logic        op_dbl = 1'b0;
    logic [5:0]  op_rd = '0;
    logic        tem_wr_en = 1'b0;
    logic [4:0]  tem_wr_data = '0;
    logic        trap_req;
    logic [31:0] status_word;
    logic [31:0] pc_o;
    logic [31:0] npc_o;
    logic [1:0]  dirty_o;

    always #4 clk = ~clk;  // 125 MHz

    fpx_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_exc(op_exc),
        .op_writes(op_writes), .op_dbl(op_dbl), .op_rd(op_rd),
        .tem_wr_en(tem_wr_en), .tem_wr_data(tem_wr_data),
        .trap_req(trap_req), .status_word(status_word),
        .pc_o(pc_o), .npc_o(npc_o), .dirty_o(dirty_o)
    );

    typedef struct {
        bit          trap;
        logic [31:0] status;
        logic [31:0] pc;
        logic [31:0] npc;
        logic [1:0]  dirty;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    // reference model
    logic [4:0]  m_tem, m_cexc, m_aexc;
    logic [2:0]  m_ftt;
    logic [31:0] m_pc, m_npc;
    logic [1:0]  m_dirty;

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s = '0;
        s[4:0]   = m_cexc;
        s[9:5]   = m_aexc;
        s[16:14] = m_ftt;
        s[27:23] = m_tem;
        return s;
    endfunction

    task automatic model_reset();
        m_tem = '0; m_cexc = '0; m_aexc = '0; m_ftt = '0;
        m_pc = RESET_PC; m_npc = RESET_PC + 32'd4; m_dirty = '0;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive_op(input logic [4:0] exc, input bit wr, input bit dbl,
                            input logic [5:0] rd, input bit twe,
                            input logic [4:0] tval, input string tag);
        exp_t e;
        bit   trap;
        @(negedge clk);
        op_done = 1'b1; op_exc = exc; op_writes = wr; op_dbl = dbl; op_rd = rd;
        tem_wr_en = twe; tem_wr_data = tval;
        trap = ((exc & m_tem) != 5'd0);
        if (exc == 5'd0) begin
            m_cexc = '0;
        end else if (trap) begin
            m_cexc = exc; m_ftt = 3'd1;
        end else begin
            m_cexc = exc; m_aexc = m_aexc | exc;
        end
        if (!trap) begin
            m_pc = m_npc; m_npc = m_npc + 32'd4;
            if (wr) m_dirty = m_dirty | ((dbl && rd >= 6'd32) ? 2'b10 : 2'b01);
        end
        if (twe) m_tem = tval;
        e.trap = trap; e.status = m_status(); e.pc = m_pc; e.npc = m_npc;
        e.dirty = m_dirty; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic go_idle(input int cycles, input logic [4:0] junk_exc);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            op_done = 1'b0; tem_wr_en = 1'b0;
            op_exc = junk_exc; op_writes = 1'b1; op_dbl = 1'b1; op_rd = 6'd45;
        end
    endtask

    task automatic write_mask(input logic [4:0] val);
        @(negedge clk);
        op_done = 1'b0; tem_wr_en = 1'b1; tem_wr_data = val;
        m_tem = val;
    endtask

    task automatic check_state(input string tag);
        @(negedge clk);
        #2;
        check(trap_req == 1'b0, tag, "trap_req", 64'(trap_req), 64'd0);
        check(status_word == m_status(), tag, "status_word", 64'(status_word), 64'(m_status()));
        check(pc_o == m_pc, tag, "pc", 64'(pc_o), 64'(m_pc));
        check(npc_o == m_npc, tag, "npc", 64'(npc_o), 64'(m_npc));
        check(dirty_o == m_dirty, tag, "dirty", 64'(dirty_o), 64'(m_dirty));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_done = 1'b0; tem_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // monitor: trap in the completion cycle, state one edge later
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && op_done) begin
                exp_t e;
                bit   got_trap;
                got_trap = trap_req;
                if (q.size() == 0) begin
                    check(1'b0, "SCOREBOARD", "unexpected completion", 64'd1, 64'd0);
                end else begin
                    e = q.pop_front();
                    check(got_trap == e.trap, e.tag, "trap_req", 64'(got_trap), 64'(e.trap));
                    @(posedge clk);
                    #2;
                    check(status_word == e.status, e.tag, "status_word", 64'(status_word), 64'(e.status));
                    check(pc_o == e.pc, e.tag, "pc", 64'(pc_o), 64'(e.pc));
                    check(npc_o == e.npc, e.tag, "npc", 64'(npc_o), 64'(e.npc));
                    check(dirty_o == e.dirty, e.tag, "dirty", 64'(dirty_o), 64'(e.dirty));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL WATCHDOG run did not complete actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state (mask zero, PC pair at reset value)
        check_state("R1");
        // R9 field layout is exercised by every status_word compare
        drive_op(5'b00000, 1'b1, 1'b0, 6'd3,  1'b0, 5'd0, "R2_R6_R7_R9");
        drive_op(5'b00001, 1'b1, 1'b0, 6'd7,  1'b0, 5'd0, "R3");
        drive_op(5'b00100, 1'b0, 1'b0, 6'd0,  1'b0, 5'd0, "R3");
        drive_op(5'b00000, 1'b0, 1'b0, 6'd0,  1'b0, 5'd0, "R2");
        go_idle(1, 5'd0);
        write_mask(5'b10000);   // invalid enabled
        go_idle(1, 5'd0);
        check_state("R8");
        // trap on invalid, back-to-back with a clean double write to upper half
        drive_op(5'b10001, 1'b1, 1'b1, 6'd40, 1'b0, 5'd0, "R4_R5");
        drive_op(5'b00000, 1'b1, 1'b1, 6'd40, 1'b0, 5'd0, "R2_R7");
        // R10: junk on operation inputs while idle
        go_idle(4, 5'b11111);
        check_state("R10");
        // R8: mask write collides with an overflow completion
        drive_op(5'b01000, 1'b0, 1'b0, 6'd0,  1'b1, 5'b01000, "R8");
        drive_op(5'b01010, 1'b1, 1'b0, 6'd2,  1'b0, 5'd0, "R8_R4");
        drive_op(5'b00010, 1'b1, 1'b1, 6'd50, 1'b0, 5'd0, "R3_R7");
        go_idle(2, 5'd0);
        // R7: dirty halves from a fresh reset
        do_reset();
        check_state("R1");
        drive_op(5'b00000, 1'b1, 1'b1, 6'd8,  1'b0, 5'd0, "R7");
        drive_op(5'b00000, 1'b1, 1'b0, 6'd33, 1'b0, 5'd0, "R7");
        go_idle(1, 5'd0);
        check_state("R7");
        drive_op(5'b00000, 1'b1, 1'b1, 6'd33, 1'b0, 5'd0, "R7");
        drive_op(5'b00011, 1'b0, 1'b0, 6'd0,  1'b0, 5'd0, "R3");
        go_idle(3, 5'd0);
        wait (q.size() == 0);
        repeat (3) @(negedge clk);
        check_state("R10");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule